// File: doc/BRIEF.md
# GPIO Bank Event Interrupt Controller

This block watches a bank of general-purpose input lines and turns selected pin activity into one interrupt request. Each line carries its own three-bit event code, taken from that line's configuration. The code picks one of five trigger conditions: falling edge, rising edge, either edge, low level or high level. Pin synchronization, glitch filtering and the storage of the per-line codes sit outside this block, and their results arrive as inputs.

A detected event latches a per-line pending bit in a status register. Reading that register returns the pending bits and clears them in the same access, so software needs no acknowledge write. An interrupt mask is built with two write-one registers, one that sets mask bits and one that clears them, and the mask can be read back. The single bank interrupt output is high while any pending bit also has its mask bit set.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset the mask and status registers read as zero and `irq_out` is low.
- R2: A write to offset 0x20 sets every mask bit whose written data bit is one and leaves the other mask bits as they were. The mask reads back at offset 0x28.
- R3: A write to offset 0x24 clears every mask bit whose written data bit is one and leaves the other mask bits as they were.
- R4: The event code of line i is `line_mode[3*i+2:3*i]`. Code 1 latches status on a 0-to-1 change of the line and code 0 on a 1-to-0 change. The status bit is set at the first clock edge that samples the new level.
- R5: Code 2 latches status on a change of the line in either direction.
- R6: Code 4 latches status on every clock edge that samples the line high, and code 3 on every edge that samples it low. A level that is still held therefore sets the bit again after a read-clear.
- R7: Codes 5, 6 and 7 never set status, whatever the line does.
- R8: A read of offset 0x2C returns the status as it stood before the access and clears it. An event detected on the clock edge of that read stays pending.
- R9: `irq_out` is high exactly when some status bit and its mask bit are both one, and it updates on the same edge as the status and mask. A masked line still latches status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| line_in | input | 32 | Synchronized, filtered line levels |
| line_mode | input | 96 | Three-bit event code per line |
| irq_out | output | 1 | Registered bank interrupt request |

## Verification
A wrong previous-level register or a wrong event decode shows up as a missing or extra status bit. It is visible on the status read that follows the pin change, which is two cycles after the change. A status bit that is not cleared, or that is cleared too eagerly, shows up on the next back-to-back read: a held level reappears, an edge does not, and an event that coincides with a read must come back on the following read. A mask or interrupt path fault is visible on `irq_out` on the edge after the status or mask change, with no extra latency to hide it.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] EV_FALL = 3'd0;
  localparam logic [MODE_W-1:0] EV_RISE = 3'd1;
  localparam logic [MODE_W-1:0] EV_BOTH = 3'd2;
  localparam logic [MODE_W-1:0] EV_LOW  = 3'd3;
  localparam logic [MODE_W-1:0] EV_HIGH = 3'd4;

  localparam logic [7:0] OFS_MASK_SET = 8'h20;
  localparam logic [7:0] OFS_MASK_CLR = 8'h24;
  localparam logic [7:0] OFS_MASK_RD  = 8'h28;
  localparam logic [7:0] OFS_STATUS   = 8'h2C;
endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        line_in,
  input  logic [NUM_LINES*MODE_W-1:0] line_mode,
  output logic [NUM_LINES-1:0]        hit
);
  logic [NUM_LINES-1:0] prev_q;

  // Previous level is captured during reset too, so no false edge follows it.
  always_ff @(posedge clk) begin
    prev_q <= line_in;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [MODE_W-1:0] code;
    logic rose, fell;
    assign code = line_mode[i*MODE_W +: MODE_W];
    assign rose = line_in[i] & ~prev_q[i];
    assign fell = ~line_in[i] & prev_q[i];

    always_comb begin
      unique case (code)
        EV_FALL: hit[i] = fell;
        EV_RISE: hit[i] = rose;
        EV_BOTH: hit[i] = rose | fell;
        EV_LOW:  hit[i] = ~line_in[i];
        EV_HIGH: hit[i] = line_in[i];
        default: hit[i] = 1'b0;
      endcase
    end

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
      (code > EV_HIGH) |-> !hit[i]); // R7
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] hit,
  input  logic                 rd_clr,
  output logic [NUM_LINES-1:0] stat_d,
  output logic [NUM_LINES-1:0] stat_q
);
  // A read clears the old pending bits; new hits on the same edge survive.
  assign stat_d = (rd_clr ? '0 : stat_q) | hit;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  AST_STAT_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stat_q == '0)); // R1

  AST_HIT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit))); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((stat_q & ~$past(hit)) == '0)); // R8
endmodule

// File: rtl/gpio_evt_mask.sv
module gpio_evt_mask #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_wr,
  input  logic                 clr_wr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] mask_d,
  output logic [NUM_LINES-1:0] mask_q
);
  always_comb begin
    mask_d = mask_q;
    if (set_wr) mask_d = mask_d | wdata;
    if (clr_wr) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  AST_MASK_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '0)); // R1

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (set_wr && !clr_wr) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !set_wr) |=> ((mask_q & $past(wdata)) == '0)); // R3
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [NUM_LINES-1:0]        bus_wdata,
  output logic [NUM_LINES-1:0]        bus_rdata,
  input  logic [NUM_LINES-1:0]        line_in,
  input  logic [NUM_LINES*MODE_W-1:0] line_mode,
  output logic                        irq_out
);
  logic [NUM_LINES-1:0] hit, stat_d, stat_q, mask_d, mask_q;
  logic sel_set, sel_clr, sel_mask, sel_stat;

  assign sel_set  = bus_addr == ADDR_W'(OFS_MASK_SET);
  assign sel_clr  = bus_addr == ADDR_W'(OFS_MASK_CLR);
  assign sel_mask = bus_addr == ADDR_W'(OFS_MASK_RD);
  assign sel_stat = bus_addr == ADDR_W'(OFS_STATUS);

  gpio_evt_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk(clk), .rst(rst), .line_in(line_in), .line_mode(line_mode), .hit(hit)
  );

  gpio_evt_status #(.NUM_LINES(NUM_LINES)) u_status (
    .clk(clk), .rst(rst), .hit(hit), .rd_clr(bus_rd && sel_stat),
    .stat_d(stat_d), .stat_q(stat_q)
  );

  gpio_evt_mask #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .set_wr(bus_wr && sel_set), .clr_wr(bus_wr && sel_clr),
    .wdata(bus_wdata), .mask_d(mask_d), .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |(stat_d & mask_d);
      if (bus_rd) begin
        if (sel_stat)      bus_rdata <= stat_q;
        else if (sel_mask) bus_rdata <= mask_q;
        else               bus_rdata <= '0;
      end
    end
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(stat_q & mask_q)); // R9

  AST_IRQ_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq_out); // R1
endmodule

// File: tb/gpio_evt_irq_bench.sv
`timescale 1ns/1ps
module gpio_evt_irq_bench;
  localparam int N = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, line_in = '0;
  logic [3*N-1:0] line_mode;
  logic irq_out;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [N-1:0] rd;

  always #10 clk = ~clk;

  gpio_evt_irq #(.NUM_LINES(N), .ADDR_W(8)) u_gpio_evt_irq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
    .line_mode(line_mode), .irq_out(irq_out));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int idx, input logic [2:0] code);
    line_mode[3*idx +: 3] = code;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [N-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 irq", {31'd0, irq_out}, '0);
    rd_reg(8'h28, rd); check("R1 mask", rd, '0);
    rd_reg(8'h2C, rd); check("R1 status", rd, '0);
  endtask

  task automatic t_mask();
    wr_reg(8'h20, 32'h0000_00F0); rd_reg(8'h28, rd); check("R2 set", rd, 32'h0000_00F0);
    wr_reg(8'h20, 32'h0000_000F); rd_reg(8'h28, rd); check("R2 or", rd, 32'h0000_00FF);
    wr_reg(8'h24, 32'h0000_003C); rd_reg(8'h28, rd); check("R3 clr", rd, 32'h0000_00C3);
    wr_reg(8'h24, 32'hFFFF_FFFF); rd_reg(8'h28, rd); check("R3 all", rd, '0);
  endtask

  task automatic t_edges();
    set_mode(0, 3'd1); set_mode(1, 3'd0); set_mode(2, 3'd2);
    @(negedge clk);
    rd_reg(8'h2C, rd); check("R4 idle", rd, '0);
    line_in[2:0] = 3'b111;
    @(negedge clk);
    rd_reg(8'h2C, rd); check("R4 R5 rise", rd, 32'h5);
    line_in[2:0] = 3'b000;
    @(negedge clk);
    rd_reg(8'h2C, rd); check("R4 R5 fall", rd, 32'h6);
    rd_reg(8'h2C, rd); check("R8 cleared", rd, '0);
  endtask

  task automatic t_level();
    set_mode(3, 3'd4); set_mode(4, 3'd3); line_in[3] = 1'b1;
    @(negedge clk);
    rd_reg(8'h2C, rd); check("R6 level", rd, 32'h18);
    rd_reg(8'h2C, rd); check("R6 reassert", rd, 32'h18);
    line_in[3] = 1'b0; line_in[4] = 1'b1;
    rd_reg(8'h2C, rd); check("R6 flush", rd, 32'h18);
    rd_reg(8'h2C, rd); check("R6 released", rd, '0);
  endtask

  task automatic t_reserved();
    for (int c = 5; c < 8; c++) begin
      set_mode(5, 3'(c));
      line_in[5] = 1'b1; @(negedge clk);
      line_in[5] = 1'b0; @(negedge clk);
      rd_reg(8'h2C, rd); check("R7 reserved", rd, '0);
    end
  endtask

  task automatic t_same_cycle();
    bus_rd = 1'b1; bus_addr = 8'h2C; line_in[0] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R8 old value", bus_rdata, '0);
    rd_reg(8'h2C, rd); check("R8 kept", rd, 32'h1);
  endtask

  task automatic t_irq();
    set_mode(6, 3'd1); set_mode(7, 3'd1); set_mode(8, 3'd1);
    wr_reg(8'h20, 32'h40);
    line_in[7] = 1'b1; @(negedge clk);
    check("R9 masked", {31'd0, irq_out}, '0);
    rd_reg(8'h2C, rd); check("R9 latched", rd, 32'h80);
    line_in[6] = 1'b1; @(negedge clk);
    check("R9 raise", {31'd0, irq_out}, 32'h1);
    rd_reg(8'h2C, rd); check("R9 status", rd, 32'h40);
    check("R9 drop", {31'd0, irq_out}, '0);
    line_in[8] = 1'b1; @(negedge clk);
    check("R9 pend masked", {31'd0, irq_out}, '0);
    wr_reg(8'h20, 32'h100);
    check("R9 unmask", {31'd0, irq_out}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) line_mode[3*i +: 3] = 3'd5;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_edges();
    t_level();
    t_reserved();
    t_same_cycle();
    t_irq();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule